// File: doc/BRIEF.md
# Register Tile Transpose and Lane Interleave Unit

This unit rearranges 16-bit lanes held in four 128-bit SIMD source rows, with no trip through memory. Each source row holds one matrix row. The unit runs one of three operations, chosen by a small opcode:

- **Transpose.** A 4x8 tile is transposed as two independent 4x4 halves. Each result row lands in its own output.
- **Even-lane merge.** Two sources are merged using their even lanes.
- **Odd-lane merge.** Two sources are merged using their odd lanes.

The two merges work on 16-bit lanes or on 32-bit lanes.

The unit accepts one operation per clock when the input valid strobe is high. The result is registered and appears one cycle later, together with the output valid strobe. A merge uses the source pairs (0,1) and (2,3): it fills outputs 0 and 1 and zeroes outputs 2 and 3. Lane k of a row occupies bits [16k+15:16k]. A 32-bit lane w occupies bits [32w+31:32w].

Top module: `xpose_unit`

## Requirements
- R1: While reset (active-low `rstN`) is held, `outValid` is 0 and all four result rows are zero.
- R2: `outValid` equals `inValid` from the previous clock. Results of an operation accepted with `inValid` high appear on the clock where `outValid` rises for it.
- R3: Opcode 0 transposes the left half of the tile. Result row N, lane i (i = 0..3), equals source row i, lane N.
- R4: Opcode 0 transposes the right half of the tile. Result row N, lane 4+j (j = 0..3), equals source row j, lane 4+N.
- R5: Opcode 1 is the 16-bit even merge. Result 0, lane 2k, is source 0, lane 2k. Result 0, lane 2k+1, is source 1, lane 2k. Result 1 is built the same way from sources 2 and 3.
- R6: Opcode 2 is the 16-bit odd merge. It works like R5 but takes lane 2k+1 of each source.
- R7: Opcodes 5 and 6 are the even and odd merges on 32-bit lanes. Opcode bit 2 selects the 32-bit lane width, and bits [1:0] select even (1) or odd (2).
- R8: After any merge, result rows 2 and 3 are zero.
- R9: Opcodes 3 and 7 produce four zero result rows. Opcode 4 acts as a transpose, because bit 2 is ignored for the transpose.
- R10: While `inValid` is low, all result rows hold their previous values, whatever the opcode and source rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| opcode | input | 3 | Operation select; bits [1:0] kind, bit 2 selects 32-bit merge lanes |
| inRow0 | input | 128 | Source row 0 |
| inRow1 | input | 128 | Source row 1 |
| inRow2 | input | 128 | Source row 2 |
| inRow3 | input | 128 | Source row 3 |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| outRow0 | output | 128 | Result row 0 |
| outRow1 | output | 128 | Result row 1 |
| outRow2 | output | 128 | Result row 2 |
| outRow3 | output | 128 | Result row 3 |

## Verification
The assertions assume three things about the inputs:

- opcode and source rows are stable across the sampling edge, and are known whenever `inValid` is high;
- no result is expected unless `inValid` was high on the previous clock;
- the operands seen under `$past` belong to a cycle after reset release.

The stimulus changes inputs one time unit after each rising edge and never drives unknowns. It leaves reset only before the first operation. It includes idle cycles carrying garbage operands, so the hold behaviour is exercised without breaking these assumptions.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
  localparam int TILE_ROWS = 4;
  localparam int OP_W = 3;

  typedef enum logic [1:0] {
    OP_TRANSPOSE = 2'd0,
    OP_EVEN      = 2'd1,
    OP_ODD       = 2'd2,
    OP_NONE      = 2'd3
  } opKind_e;

  typedef struct packed {
    logic load;
    logic doTranspose;
    logic doInterleave;
    logic pickOdd;
    logic wide;
  } ctlStrobe_t;
endpackage

// File: rtl/xpose_ctrl.sv
module xpose_ctrl
  import xpose_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] opcode,
  output ctlStrobe_t      ctl,
  output logic            outValid
);
  opKind_e kind;

  always_comb begin
    kind             = opKind_e'(opcode[1:0]);
    ctl.load         = inValid;
    ctl.doTranspose  = (kind == OP_TRANSPOSE);
    ctl.doInterleave = (kind == OP_EVEN) || (kind == OP_ODD);
    ctl.pickOdd      = (kind == OP_ODD);
    ctl.wide         = opcode[2] && ctl.doInterleave;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/xpose_dp.sv
module xpose_dp
  import xpose_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              ctl,
  input  logic [LANE_W*LANES-1:0] inRow  [TILE_ROWS],
  output logic [LANE_W*LANES-1:0] outRow [TILE_ROWS]
);
  localparam int ROW_W  = LANE_W * LANES;
  localparam int PAIRS  = TILE_ROWS / 2;
  localparam int WIDE_W = 2 * LANE_W;
  localparam int WIDE_N = LANES / 2;

  logic [ROW_W-1:0] tpRow     [TILE_ROWS];
  logic [ROW_W-1:0] narrowRow [PAIRS];
  logic [ROW_W-1:0] wideRow   [PAIRS];
  logic [ROW_W-1:0] nextRow   [TILE_ROWS];
  logic [ROW_W-1:0] rowQ      [TILE_ROWS];

  // Transpose: each half of the tile is a square of TILE_ROWS lanes
  for (genvar n = 0; n < TILE_ROWS; n++) begin : g_tpRow
    for (genvar i = 0; i < LANES; i++) begin : g_tpLane
      assign tpRow[n][i*LANE_W +: LANE_W] =
        inRow[i % TILE_ROWS][((i / TILE_ROWS) * TILE_ROWS + n) * LANE_W +: LANE_W];
    end
  end

  // Merges: pair p combines source rows 2p and 2p+1
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    for (genvar k = 0; k < LANES; k++) begin : g_narrow
      assign narrowRow[p][k*LANE_W +: LANE_W] = ctl.pickOdd ?
        inRow[2*p + k%2][((k/2)*2 + 1) * LANE_W +: LANE_W] :
        inRow[2*p + k%2][((k/2)*2) * LANE_W +: LANE_W];
    end
    for (genvar w = 0; w < WIDE_N; w++) begin : g_wide
      assign wideRow[p][w*WIDE_W +: WIDE_W] = ctl.pickOdd ?
        inRow[2*p + w%2][((w/2)*2 + 1) * WIDE_W +: WIDE_W] :
        inRow[2*p + w%2][((w/2)*2) * WIDE_W +: WIDE_W];
    end
  end

  always_comb begin
    for (int r = 0; r < TILE_ROWS; r++) nextRow[r] = '0;
    if (ctl.doTranspose) begin
      for (int r = 0; r < TILE_ROWS; r++) nextRow[r] = tpRow[r];
    end else if (ctl.doInterleave) begin
      for (int r = 0; r < PAIRS; r++) nextRow[r] = ctl.wide ? wideRow[r] : narrowRow[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < TILE_ROWS; r++) rowQ[r] <= '0;
    end else if (ctl.load) begin
      for (int r = 0; r < TILE_ROWS; r++) rowQ[r] <= nextRow[r];
    end
  end

  for (genvar r = 0; r < TILE_ROWS; r++) begin : g_out
    assign outRow[r] = rowQ[r];
  end

  // R3
  tp_corner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.doTranspose) |=>
      (rowQ[1][LANE_W-1:0] == $past(inRow[0][2*LANE_W-1:LANE_W])) &&
      (rowQ[0][2*LANE_W-1:LANE_W] == $past(inRow[1][LANE_W-1:0])));
  // R5
  even_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.doInterleave && !ctl.pickOdd && !ctl.wide) |=>
      (rowQ[0][2*LANE_W-1:LANE_W] == $past(inRow[1][LANE_W-1:0])));
  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.doInterleave) |=> (rowQ[2] == '0) && (rowQ[3] == '0));
  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.doTranspose && !ctl.doInterleave) |=>
      (rowQ[0] == '0) && (rowQ[1] == '0) && (rowQ[2] == '0) && (rowQ[3] == '0));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(rowQ[0]) && $stable(rowQ[1]) && $stable(rowQ[2]) && $stable(rowQ[3]));
endmodule

// File: rtl/xpose_unit.sv
module xpose_unit
  import xpose_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [OP_W-1:0]         opcode,
  input  logic [LANE_W*LANES-1:0] inRow0,
  input  logic [LANE_W*LANES-1:0] inRow1,
  input  logic [LANE_W*LANES-1:0] inRow2,
  input  logic [LANE_W*LANES-1:0] inRow3,
  output logic                    outValid,
  output logic [LANE_W*LANES-1:0] outRow0,
  output logic [LANE_W*LANES-1:0] outRow1,
  output logic [LANE_W*LANES-1:0] outRow2,
  output logic [LANE_W*LANES-1:0] outRow3
);
  localparam int ROW_W = LANE_W * LANES;

  ctlStrobe_t       ctl;
  logic [ROW_W-1:0] srcRows [TILE_ROWS];
  logic [ROW_W-1:0] resRows [TILE_ROWS];

  assign srcRows[0] = inRow0;
  assign srcRows[1] = inRow1;
  assign srcRows[2] = inRow2;
  assign srcRows[3] = inRow3;

  xpose_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .ctl(ctl), .outValid(outValid)
  );

  xpose_dp #(.LANE_W(LANE_W), .LANES(LANES)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inRow(srcRows), .outRow(resRows)
  );

  assign outRow0 = resRows[0];
  assign outRow1 = resRows[1];
  assign outRow2 = resRows[2];
  assign outRow3 = resRows[3];
endmodule

// File: tb/xpose_unit_tb.sv
`timescale 1ns/1ps
module xpose_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] opcode = 3'd0;
  logic [127:0] inRow0 = '0, inRow1 = '0, inRow2 = '0, inRow3 = '0;
  logic outValid;
  logic [127:0] outRow0, outRow1, outRow2, outRow3;

  int total = 0;
  int bad = 0;

  logic [127:0] expRow [4];
  logic expValid = 1'b0;

  always #2 clk = ~clk;

  xpose_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .inRow0(inRow0), .inRow1(inRow1), .inRow2(inRow2), .inRow3(inRow3),
    .outValid(outValid),
    .outRow0(outRow0), .outRow1(outRow1), .outRow2(outRow2), .outRow3(outRow3)
  );

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lane16(input logic [127:0] r, input int i);
    return r[i*16 +: 16];
  endfunction

  // Reference: apply one accepted operation to the model state
  task automatic modelOp(input logic [2:0] op, input logic [127:0] s [4]);
    logic [127:0] res [4];
    for (int r = 0; r < 4; r++) res[r] = '0;
    if (op[1:0] == 2'd0) begin
      for (int n = 0; n < 4; n++)
        for (int i = 0; i < 8; i++) begin
          int e = (i & 3) * 8 + (i & ~3) + n;
          res[n][i*16 +: 16] = lane16(s[e / 8], e % 8);
        end
    end else if (op[1:0] != 2'd3) begin
      int g = op[2] ? 32 : 16;
      int cnt = 128 / g;
      int odd = (op[1:0] == 2'd2) ? 1 : 0;
      for (int p = 0; p < 2; p++)
        for (int j = 0; j < cnt; j++) begin
          int idx = (j - (j % 2)) + odd;
          logic [127:0] src = s[2*p + (j % 2)];
          for (int b = 0; b < g; b++) res[p][j*g + b] = src[idx*g + b];
        end
    end
    for (int r = 0; r < 4; r++) expRow[r] = res[r];
  endtask

  task automatic step(input logic v, input logic [2:0] op,
                      input logic [127:0] a, input logic [127:0] b,
                      input logic [127:0] c, input logic [127:0] d);
    logic [127:0] s [4];
    string tag;
    s[0] = a; s[1] = b; s[2] = c; s[3] = d;
    inValid = v; opcode = op;
    inRow0 = a; inRow1 = b; inRow2 = c; inRow3 = d;
    if (v) modelOp(op, s);
    expValid = v;
    if (!v) tag = "R10 hold";
    else if (op == 3'd4) tag = "R9 R3 R4 opcode4";
    else if (op[1:0] == 2'd0) tag = "R3 R4 transpose";
    else if (op[1:0] == 2'd3) tag = "R9 unknown";
    else if (op[2]) tag = "R7 wide merge";
    else if (op[1:0] == 2'd1) tag = "R5 even merge";
    else tag = "R6 odd merge";
    @(posedge clk);
    #1;
    check("R2 valid", {511'd0, outValid}, {511'd0, expValid});
    check(tag, {outRow3, outRow2, outRow1, outRow0},
               {expRow[3], expRow[2], expRow[1], expRow[0]});
    if (v && (op[1:0] == 2'd1 || op[1:0] == 2'd2))
      check("R8 upper zero", {256'd0, outRow3, outRow2}, 512'd0);
  endtask

  function automatic logic [127:0] pat(input int r);
    logic [127:0] x;
    for (int i = 0; i < 8; i++) x[i*16 +: 16] = 16'(16'h1000 * (r + 1) + i);
    return x;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #(4 * 50000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) expRow[r] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {511'd0, outValid}, 512'd0);
    check("R1 reset rows", {outRow3, outRow2, outRow1, outRow0}, 512'd0);
    rstN = 1'b1;

    step(1'b1, 3'd0, pat(0), pat(1), pat(2), pat(3));
    step(1'b0, 3'd1, rnd128(), rnd128(), rnd128(), rnd128());
    step(1'b0, 3'd3, rnd128(), rnd128(), rnd128(), rnd128());
    step(1'b1, 3'd1, pat(0), pat(1), pat(2), pat(3));
    step(1'b1, 3'd2, pat(0), pat(1), pat(2), pat(3));
    step(1'b1, 3'd5, pat(0), pat(1), pat(2), pat(3));
    step(1'b1, 3'd6, pat(0), pat(1), pat(2), pat(3));
    step(1'b1, 3'd3, pat(0), pat(1), pat(2), pat(3));
    step(1'b1, 3'd4, pat(3), pat(2), pat(1), pat(0));
    step(1'b1, 3'd7, pat(0), pat(1), pat(2), pat(3));
    step(1'b1, 3'd0, {128{1'b1}}, '0, {8{16'hA5A5}}, {8{16'h5A5A}});
    step(1'b0, 3'd0, rnd128(), rnd128(), rnd128(), rnd128());

    for (int k = 0; k < 400; k++) begin
      logic v = ($urandom_range(0, 9) < 7);
      step(v, 3'($urandom_range(0, 7)), rnd128(), rnd128(), rnd128(), rnd128());
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule